// File: doc/BRIEF.md
# Pair-Mergeable Center-Aligned PWM Timer

This block drives six pulse-width modulated pins, each from its own up/down counter. A channel counts up from 1 to its period value and then back down to 0, so one output period spans twice the period value in channel ticks. The pin is high during a symmetric window around the top of the count. The duty value sets the width of that window. The polarity bit picks whether the window is the low part or the high part of the waveform. Each channel advances only on clock cycles where its own tick input is high, so an external prescaler sets the time base.

Any adjacent pair (0,1), (2,3) or (4,5) can be merged into one channel with a 16-bit period and duty. In a merged pair the lower-numbered channel's period and duty registers supply the upper byte. The higher-numbered channel's enable, polarity and tick run the counter, and its pin carries the waveform. The lower pin rests at its polarity level. Period and duty writes are staged and only reach the counter at the end of a period or while the channel is off, so a period is never cut short. Software sets the block up through a simple single-cycle write port.

Each channel engine is a three-state machine. OFF holds the counter at 0, follows the register values into the staging copies and drives the pin to the polarity level. OFF moves to DOWN, parked at count 0, in the cycle after the enable is seen. In DOWN at count 0 a tick loads the staged values: a zero period stays in DOWN at 0, otherwise the counter moves to UP with count 1. In UP a tick increments the count, and at count equal to period it moves to DOWN with period − 1. In DOWN a tick decrements the count. Dropping the enable returns any state to OFF.

Top module: `cpwm_timer`

## Requirements
- R1: With a period value P > 0 and a tick on every cycle, the output waveform repeats every 2·P cycles and has exactly one rising edge per period when its high time is neither 0 nor 2·P.
- R2: With polarity 0, the pin is high for 2·(P − D) ticks of each period when the duty value D ≤ P, and low all the time when D ≥ P. D = 0 gives a constant high output. For P = 4, D = 1 this is 6 of 8 ticks (75 %).
- R3: With polarity 1, the pin is high for 2·D ticks of each period when D ≤ P, and high all the time when D ≥ P.
- R4: A channel's counter advances only on cycles where that channel's tick input bit is 1. A tick on every second cycle doubles the output period in clock cycles.
- R5: Merge bit k (write address 2, bit k) joins channels 2k and 2k+1 into one channel. Its period is {PER[2k], PER[2k+1]} and its duty is {DTY[2k], DTY[2k+1]}, with the lower channel holding the upper byte.
- R6: In a merged pair, the enable, polarity and tick of channel 2k+1 govern the counter and its waveform drives pin 2k+1. Pin 2k holds the level of polarity bit 2k, whatever channel 2k's enable is.
- R7: A write to merge bit k is ignored while channel 2k or channel 2k+1 is enabled. It takes effect when both are disabled.
- R8: Period and duty writes made while a channel runs take effect only when its counter returns to 0. A running channel's staged values never change in any other cycle.
- R9: An enabled channel whose period value is 0 holds its pin at its polarity bit.
- R10: A disabled channel holds its counter at 0 and drives its pin to its polarity bit. After reset every register is 0 and every pin is low.
- R11: Register map (5-bit address, 8-bit data): address 0 holds the enable bits (bit n for channel n), address 1 the polarity bits, address 2 the merge bits, address 8+n the period of channel n and address 16+n the duty of channel n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 6 | Per-channel count enable, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 6 | PWM pins, bit n for channel n |

## Verification
The bench builds the block with its default six channels of 8 bits. At that width the small periods used for the shape checks give waveforms a few tens of cycles long. A merged 16-bit period of 260 ticks (upper byte 1) also fits in about a thousand cycles, so the byte-order check is exact and cheap. Tick gating on one channel and zero-period or oversized-duty settings reach the edge cases of the compare. Merge writes are made while the pair runs, so the lock is observed through the waveform that stays merged.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } eng_state_t;

    localparam int ADDR_W   = 5;
    localparam int ADR_EN   = 0;
    localparam int ADR_POL  = 1;
    localparam int ADR_MRG  = 2;
    localparam int ADR_PER  = 8;
    localparam int ADR_DTY  = 16;

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int NCH = 6,
    parameter int W   = 8,
    localparam int NPAIR = NCH / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [W-1:0]               wr_data,
    output logic [NCH-1:0]             en_q,
    output logic [NCH-1:0]             pol_q,
    output logic [NPAIR-1:0]           mrg_q,
    output logic [NCH-1:0][W-1:0]      per_q,
    output logic [NCH-1:0][W-1:0]      dty_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_EN))  en_q  <= wr_data[NCH-1:0];
            if (wr_addr == ADDR_W'(ADR_POL)) pol_q <= wr_data[NCH-1:0];
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                per_q[n] <= '0;
                dty_q[n] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADDR_W'(ADR_PER + n)) per_q[n] <= wr_data;
                if (wr_addr == ADDR_W'(ADR_DTY + n)) dty_q[n] <= wr_data;
            end
        end
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_mrg
        logic pair_idle;
        assign pair_idle = ~en_q[2*k] & ~en_q[2*k+1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mrg_q[k] <= 1'b0;
            else if (wr_en && wr_addr == ADDR_W'(ADR_MRG) && pair_idle)
                mrg_q[k] <= wr_data[k];
        end

        AST_MERGE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[2*k] || en_q[2*k+1]) |=> $stable(mrg_q[k])); // R7
    end

endmodule

// File: rtl/cpwm_route.sv
module cpwm_route #(
    parameter int NCH = 6,
    parameter int W   = 8,
    localparam int NPAIR = NCH / 2,
    localparam int CW    = 2 * W
) (
    input  logic [NCH-1:0]             en_q,
    input  logic [NCH-1:0]             pol_q,
    input  logic [NPAIR-1:0]           mrg_q,
    input  logic [NCH-1:0][W-1:0]      per_q,
    input  logic [NCH-1:0][W-1:0]      dty_q,
    input  logic [NCH-1:0]             tick_i,
    output logic [NCH-1:0]             run_e,
    output logic [NCH-1:0]             pol_e,
    output logic [NCH-1:0]             tick_e,
    output logic [NCH-1:0][CW-1:0]     per_e,
    output logic [NCH-1:0][CW-1:0]     dty_e
);

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int LO = 2 * k;
        localparam int HI = 2 * k + 1;

        // lower-numbered channel: silenced when merged
        assign run_e[LO]  = en_q[LO] & ~mrg_q[k];
        assign pol_e[LO]  = pol_q[LO];
        assign tick_e[LO] = tick_i[LO];
        assign per_e[LO]  = {{W{1'b0}}, per_q[LO]};
        assign dty_e[LO]  = {{W{1'b0}}, dty_q[LO]};

        // higher-numbered channel: owns the 16-bit counter when merged
        assign run_e[HI]  = en_q[HI];
        assign pol_e[HI]  = pol_q[HI];
        assign tick_e[HI] = tick_i[HI];
        assign per_e[HI]  = mrg_q[k] ? {per_q[LO], per_q[HI]} : {{W{1'b0}}, per_q[HI]};
        assign dty_e[HI]  = mrg_q[k] ? {dty_q[LO], dty_q[HI]} : {{W{1'b0}}, dty_q[HI]};
    end

endmodule

// File: rtl/cpwm_engine.sv
module cpwm_engine
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          pol,
    input  logic [CW-1:0] per_in,
    input  logic [CW-1:0] dty_in,
    output logic          pwm
);

    eng_state_t    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] per_b;
    logic [CW-1:0] dty_b;

    // state register, counter and staging copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
            per_b <= '0;
            dty_b <= '0;
        end else if (!run) begin
            state <= ST_OFF;
            cnt   <= '0;
            per_b <= per_in;
            dty_b <= dty_in;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state <= ST_DOWN;
                end
                ST_UP: begin
                    if (tick) begin
                        if (cnt >= per_b) begin
                            state <= ST_DOWN;
                            cnt   <= cnt - 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DOWN: begin
                    if (tick) begin
                        if (cnt == '0) begin
                            per_b <= per_in;
                            dty_b <= dty_in;
                            if (per_in != '0) begin
                                state <= ST_UP;
                                cnt   <= CW'(1);
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_OFF;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // output decode
    logic active;
    always_comb begin
        active = 1'b0;
        unique case (state)
            ST_OFF:  active = 1'b0;
            ST_UP:   active = (per_b != '0) && (cnt > dty_b);
            ST_DOWN: active = (per_b != '0) && (cnt >= dty_b);
            default: active = 1'b0;
        endcase
        pwm = pol ^ active;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |-> (cnt <= per_b)); // R1

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state != ST_OFF && !(state == ST_DOWN && cnt == '0 && tick))
        |=> $stable(per_b) && $stable(dty_b)); // R8

    AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && state != ST_OFF) |=> $stable(cnt)); // R4

    AST_ZERO_PER: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_b == '0) |-> (pwm == pol)); // R9

    AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0) && (pwm == pol)); // R10

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
    import cpwm_pkg::*;
#(
    parameter int NCH = 6,
    parameter int W   = 8,
    localparam int NPAIR = NCH / 2,
    localparam int CW    = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tick_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [NCH-1:0]    pwm_o
);

    logic [NCH-1:0]          en_q;
    logic [NCH-1:0]          pol_q;
    logic [NPAIR-1:0]        mrg_q;
    logic [NCH-1:0][W-1:0]   per_q;
    logic [NCH-1:0][W-1:0]   dty_q;

    logic [NCH-1:0]          run_e;
    logic [NCH-1:0]          pol_e;
    logic [NCH-1:0]          tick_e;
    logic [NCH-1:0][CW-1:0]  per_e;
    logic [NCH-1:0][CW-1:0]  dty_e;

    cpwm_regs #(.NCH(NCH), .W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_q    (en_q),
        .pol_q   (pol_q),
        .mrg_q   (mrg_q),
        .per_q   (per_q),
        .dty_q   (dty_q)
    );

    cpwm_route #(.NCH(NCH), .W(W)) u_route (
        .en_q   (en_q),
        .pol_q  (pol_q),
        .mrg_q  (mrg_q),
        .per_q  (per_q),
        .dty_q  (dty_q),
        .tick_i (tick_i),
        .run_e  (run_e),
        .pol_e  (pol_e),
        .tick_e (tick_e),
        .per_e  (per_e),
        .dty_e  (dty_e)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_eng
        cpwm_engine #(.CW(CW)) u_eng (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_e[n]),
            .tick   (tick_e[n]),
            .pol    (pol_e[n]),
            .per_in (per_e[n]),
            .dty_in (dty_e[n]),
            .pwm    (pwm_o[n])
        );
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_chk
        AST_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mrg_q[k]) && mrg_q[k] |-> (pwm_o[2*k] == pol_q[2*k])); // R6
    end

endmodule

// File: tb/cpwm_timer_test.sv
module cpwm_timer_test;

    localparam int NCH = 6;
    localparam int W   = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] tick_i;
    logic           wr_en = 1'b0;
    logic [4:0]     wr_addr = '0;
    logic [W-1:0]   wr_data = '0;
    logic [NCH-1:0] pwm_o;

    logic slow = 1'b0;
    logic phase = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    always @(negedge clk) phase <= ~phase;
    assign tick_i = slow ? {1'b1, phase, 4'b1111} : {NCH{1'b1}};

    cpwm_timer #(.NCH(NCH), .W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        int    ch;
        int    cycles;
        int    exp_high;
        int    exp_edges;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic     mon_busy = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 5'(addr);
        wr_data = W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: push expectation, wait for monitor to consume it
    task automatic expect_wave(input int ch, input int cycles, input int hi,
                               input int edges, input string tag);
        sb_item_t it;
        it.ch = ch; it.cycles = cycles; it.exp_high = hi;
        it.exp_edges = edges; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    // monitor side: measure the pin and compare
    initial begin
        forever begin
            sb_item_t it;
            int hi;
            int ed;
            logic prev;
            wait (sb_q.size() > 0);
            mon_busy = 1'b1;
            it = sb_q.pop_front();
            hi = 0; ed = 0;
            @(negedge clk);
            prev = pwm_o[it.ch];
            for (int i = 0; i < it.cycles; i++) begin
                if (i > 0) @(negedge clk);
                if (pwm_o[it.ch]) hi++;
                if (i > 0 && !prev && pwm_o[it.ch]) ed++;
                prev = pwm_o[it.ch];
            end
            check(hi == it.exp_high, {it.tag, " high"}, hi, it.exp_high);
            if (it.exp_edges >= 0)
                check(ed == it.exp_edges, {it.tag, " edges"}, ed, it.exp_edges);
            mon_busy = 1'b0;
        end
    end

    initial begin
        #(20ns * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);
        check(pwm_o == 6'b0, "R10 reset pins", int'(pwm_o), 0);

        // R1 R2 R11: P=4 D=1 pol0 on channel 3 -> 6 of 8 high
        wr(8 + 3, 4);
        wr(16 + 3, 1);
        wr(0, 6'b001000);
        settle(20);
        expect_wave(3, 80, 60, 10, "R1 R2 ch3 P4 D1 pol0");

        // R3: same, polarity 1 -> 2 of 8 high
        wr(1, 6'b001000);
        settle(20);
        expect_wave(3, 80, 20, 10, "R3 ch3 P4 D1 pol1");

        // R2: duty 0 pol0 -> constant high
        wr(8 + 0, 5);
        wr(16 + 0, 0);
        wr(1, 6'b000000);
        wr(0, 6'b001001);
        settle(20);
        expect_wave(0, 100, 100, 0, "R2 ch0 D0 full high");

        // R3: duty above period with pol1 -> constant high
        wr(8 + 1, 3);
        wr(16 + 1, 7);
        wr(1, 6'b000010);
        wr(0, 6'b001011);
        settle(20);
        expect_wave(1, 60, 60, 0, "R3 ch1 D>P pol1");

        // R9: period 0 -> polarity level
        wr(8 + 2, 0);
        wr(16 + 2, 2);
        wr(1, 6'b000110);
        wr(0, 6'b001111);
        settle(20);
        expect_wave(2, 50, 50, 0, "R9 ch2 P0 pol1");
        wr(1, 6'b000010);
        settle(10);
        expect_wave(2, 50, 0, 0, "R9 ch2 P0 pol0");

        // R4: tick every second cycle on channel 4
        slow = 1'b1;
        wr(8 + 4, 4);
        wr(16 + 4, 1);
        wr(0, 6'b011111);
        settle(40);
        expect_wave(4, 160, 120, 10, "R4 ch4 half-rate tick");
        slow = 1'b0;

        // R5 R6: merge pair 0/1 -> P=260 D=65 pol1=0, pin0 at pol0=1
        wr(0, 6'b000000);
        settle(3);
        wr(2, 3'b001);
        wr(8 + 0, 1);
        wr(8 + 1, 4);
        wr(16 + 0, 0);
        wr(16 + 1, 65);
        wr(1, 6'b000001);
        wr(0, 6'b000011);
        settle(10);
        expect_wave(1, 1040, 780, 2, "R5 merged 16-bit ch1");
        expect_wave(0, 100, 100, 0, "R6 merged low pin idle");

        // R7: merge write while running is ignored
        wr(2, 3'b000);
        settle(5);
        expect_wave(1, 1040, 780, 2, "R7 merge locked");

        // R7: after disabling, unmerge takes effect: 8-bit P=4 D=65 pol0 -> low
        wr(0, 6'b000000);
        settle(3);
        wr(2, 3'b000);
        wr(0, 6'b000010);
        settle(20);
        expect_wave(1, 80, 0, 0, "R7 unmerged after idle");

        // R8: staged update while running
        wr(1, 6'b000000);
        wr(8 + 3, 4);
        wr(16 + 3, 1);
        wr(0, 6'b001000);
        settle(20);
        wr(16 + 3, 3);
        settle(20);
        expect_wave(3, 80, 20, 10, "R8 duty update");
        wr(8 + 3, 6);
        settle(30);
        expect_wave(3, 120, 60, 10, "R8 period update");

        // R10: disabled channel follows polarity
        wr(0, 6'b000000);
        wr(1, 6'b001000);
        settle(3);
        check(pwm_o[3] == 1'b1, "R10 disabled pol1", int'(pwm_o[3]), 1);
        wr(1, 6'b000000);
        settle(3);
        check(pwm_o[3] == 1'b0, "R10 disabled pol0", int'(pwm_o[3]), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule